// File: doc/BRIEF.md
# Flash Calibration Overlay Remapper

This block watches the word address of every access on a data bus that reads from flash memory. It checks each address against eight programmable address windows. When a data read falls inside an enabled window, the block signals a hit, tells the bus side to block the flash data, and gives the word address in a local calibration RAM where the replacement data lives. A calibration tool can then tune constants while the flash keeps its original contents.

The eight windows map onto one contiguous RAM. Window k owns the k-th 512-byte slice of the RAM, and each window fills its slice from the lowest address upward. A window's size is a power of two from 4 to 512 bytes. Its flash base is word-granular and is aligned down to the window size when addresses are matched. A module disable bit puts the RAM into a low-power state. In that state every direct access to the RAM is flagged as an error and no overlay takes place.

All outputs are registered. A request sampled at clock edge t shows its result just after edge t. The bench's synchronous RAM, addressed by that result, then returns data one cycle later, which is the same latency as the flash path.

Top module: `cal_overlay_remap`

## Requirements
- R1: The configuration port decodes the index: 0 to 7 write region k as {base[18:0], size[3:0]}, with the size in bits 3:0 and the flash word address in bits 22:4. Index 8 writes the control register, whose disable bit is bit 0. Indexes 9 to 15 change nothing.
- R2: Size codes 1 to 8 give windows of 4, 8, 16, 32, 64, 128, 256 and 512 bytes. Codes 9 to 15 give 512 bytes.
- R3: A region with size code 0 never hits.
- R4: Base address bits below the window size are treated as zero during matching.
- R5: On a hit, ram_addr = region×128 + the word-address bits below the window size. It is 0 when there is no hit.
- R6: Only a data read hits. That means bus_rd=1, bus_wr=0, bus_is_data=1 and ram_sel=0. Fetches, writes and direct RAM accesses never hit.
- R7: ovl_hit, flash_suppress and ram_addr appear in the cycle after the request is sampled, and flash_suppress equals ovl_hit.
- R8: While the disable bit is set, a request with ram_sel=1 and bus_rd or bus_wr raises acc_err in the following cycle. Otherwise acc_err is 0.
- R9: While the disable bit is set, no hit occurs. Clearing the bit restores overlay behaviour.
- R10: When several enabled regions match, the lowest-numbered region wins.
- R11: After reset, all outputs are 0, every size code is 0 and the disable bit is clear.
- R12: A configuration write sampled at edge t affects only requests sampled at edge t+1 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_waddr | input | 19 | Bus word address (byte address bits 20:2) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| ram_sel | input | 1 | Access targets the calibration RAM directly |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 23 | Configuration write data |
| ovl_hit | output | 1 | Overlay hit for the previous request |
| flash_suppress | output | 1 | Block flash data on the bus |
| ram_addr | output | 10 | Calibration RAM word address |
| acc_err | output | 1 | RAM access while disabled |

## Verification
A configuration write and an overlay lookup can both happen at the same clock edge. This includes a write to the disable bit. The bench provokes this deliberately, for example by writing size 0 to a region while reading inside it, or by setting the disable bit during a hitting read. It then judges the result with the rule that the lookup uses the configuration from before the write. Random traffic mixes configuration writes with reads on most cycles. A bench model updated only after each edge predicts the hit, RAM address and error.

// File: rtl/cal_ovl_pkg.sv
package cal_ovl_pkg;
  localparam int NUM_RGN   = 8;
  localparam int RGN_BYTES = 512;
  localparam int WADDR_W   = 19;
  localparam int SIZE_W    = 4;
  localparam int CFG_IW    = 4;
  localparam int CFG_DW    = SIZE_W + WADDR_W;
  localparam int RGN_WORDS = RGN_BYTES / 4;
  localparam int OFS_W     = $clog2(RGN_WORDS);
  localparam int RIDX_W    = $clog2(NUM_RGN);
  localparam int RAM_AW    = RIDX_W + OFS_W;
  localparam int MAX_CODE  = OFS_W + 1;
  localparam int CTL_IDX   = NUM_RGN;

  typedef struct packed {
    logic [WADDR_W-1:0] base;
    logic [SIZE_W-1:0]  size;
  } rgn_cfg_t;

  // number of word-address bits that fall inside a window of the given code
  function automatic int unsigned win_low_bits(input logic [SIZE_W-1:0] code);
    if (code == '0)                return 0;
    else if (int'(code) > MAX_CODE) return OFS_W;
    else                           return int'(code) - 1;
  endfunction
endpackage

// File: rtl/cal_ovl_regs.sv
module cal_ovl_regs
  import cal_ovl_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [CFG_IW-1:0]             cfg_idx,
  input  logic [CFG_DW-1:0]             cfg_wdata,
  output rgn_cfg_t [NUM_RGN-1:0]        rgn_cfg,
  output logic                          ctl_dis
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rgn_cfg <= '0;
      ctl_dis <= 1'b0;
    end else if (cfg_we) begin
      if (int'(cfg_idx) < NUM_RGN)
        rgn_cfg[cfg_idx[RIDX_W-1:0]] <= rgn_cfg_t'(cfg_wdata);
      else if (int'(cfg_idx) == CTL_IDX)
        ctl_dis <= cfg_wdata[0];
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (rgn_cfg == '0 && !ctl_dis)); // R11
endmodule

// File: rtl/cal_ovl_window.sv
module cal_ovl_window
  import cal_ovl_pkg::*;
(
  input  rgn_cfg_t            cfg,
  input  logic [WADDR_W-1:0]  waddr,
  output logic                match,
  output logic [OFS_W-1:0]    ofs
);
  logic [WADDR_W-1:0] one_w;
  logic [WADDR_W-1:0] low_mask;
  int unsigned        nlow;

  assign one_w = {{(WADDR_W-1){1'b0}}, 1'b1};

  always_comb begin
    nlow     = win_low_bits(cfg.size);
    low_mask = (one_w << nlow) - one_w;
    match    = (cfg.size != '0) && (((waddr ^ cfg.base) & ~low_mask) == '0);
    ofs      = waddr[OFS_W-1:0] & low_mask[OFS_W-1:0];
  end
endmodule

// File: rtl/cal_ovl_prio.sv
module cal_ovl_prio
  import cal_ovl_pkg::*;
(
  input  logic [NUM_RGN-1:0] req,
  output logic               any,
  output logic [RIDX_W-1:0]  sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        sel = RIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cal_overlay_remap.sv
module cal_overlay_remap
  import cal_ovl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [WADDR_W-1:0]  bus_waddr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic                bus_is_data,
  input  logic                ram_sel,
  input  logic                cfg_we,
  input  logic [CFG_IW-1:0]   cfg_idx,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  output logic                ovl_hit,
  output logic                flash_suppress,
  output logic [RAM_AW-1:0]   ram_addr,
  output logic                acc_err
);
  rgn_cfg_t [NUM_RGN-1:0] rgn_cfg;
  logic                   ctl_dis;
  logic [NUM_RGN-1:0]     win_match;
  logic [OFS_W-1:0]       win_ofs [NUM_RGN];
  logic                   any_match;
  logic [RIDX_W-1:0]      win_sel;
  logic                   data_rd;
  logic                   hit_d;

  cal_ovl_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .rgn_cfg   (rgn_cfg),
    .ctl_dis   (ctl_dis)
  );

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_win
    cal_ovl_window u_win (
      .cfg   (rgn_cfg[g]),
      .waddr (bus_waddr),
      .match (win_match[g]),
      .ofs   (win_ofs[g])
    );
  end

  cal_ovl_prio u_prio (
    .req (win_match),
    .any (any_match),
    .sel (win_sel)
  );

  assign data_rd = bus_rd && !bus_wr && bus_is_data && !ram_sel;
  assign hit_d   = data_rd && !ctl_dis && any_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_hit        <= 1'b0;
      flash_suppress <= 1'b0;
      ram_addr       <= '0;
      acc_err        <= 1'b0;
    end else begin
      ovl_hit        <= hit_d;
      flash_suppress <= hit_d;
      ram_addr       <= hit_d ? {win_sel, win_ofs[win_sel]} : '0;
      acc_err        <= ctl_dis && ram_sel && (bus_rd || bus_wr);
    end
  end

  AST_DATA_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    ovl_hit |-> $past(bus_rd && !bus_wr && bus_is_data && !ram_sel)); // R6
  AST_DIS_BLOCKS_HIT: assert property (@(posedge clk) disable iff (rst)
    ovl_hit |-> !$past(ctl_dis)); // R9
  AST_ERR_WHEN_DIS: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_dis && ram_sel && (bus_rd || bus_wr)) |-> acc_err); // R8
  AST_ERR_NEEDS_DIS: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(ctl_dis)); // R8
  AST_NO_HIT_WITHOUT_MATCH: assert property (@(posedge clk) disable iff (rst)
    ovl_hit |-> $past(any_match)); // R3
endmodule

// File: tb/tb_cal_overlay_remap.sv
module tb_cal_overlay_remap;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] bus_waddr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_is_data = 1'b0, ram_sel = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [22:0] cfg_wdata = '0;
  logic        ovl_hit, flash_suppress, acc_err;
  logic [9:0]  ram_addr;

  int n_chk = 0, n_fail = 0;
  logic [18:0] m_base [8];
  logic [3:0]  m_size [8];
  logic        m_dis;

  always #(CLK_P/2) clk = ~clk;

  cal_overlay_remap dut (
    .clk(clk), .rst(rst), .bus_waddr(bus_waddr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_is_data(bus_is_data), .ram_sel(ram_sel), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .ovl_hit(ovl_hit), .flash_suppress(flash_suppress),
    .ram_addr(ram_addr), .acc_err(acc_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [18:0] a, input logic rd, wr, isd, sel,
                       output logic eh, output logic [9:0] ea, output logic ee);
    eh = 1'b0; ea = '0;
    ee = m_dis && sel && (rd || wr);
    if (rd && !wr && isd && !sel && !m_dis) begin
      for (int i = 0; i < 8; i++) begin
        if (!eh && m_size[i] != 0) begin
          int k;
          k = (m_size[i] > 8) ? 7 : int'(m_size[i]) - 1;
          if ((a >> k) == (m_base[i] >> k)) begin
            eh = 1'b1;
            ea = 10'(i * 128) + 10'(a & ((19'd1 << k) - 19'd1));
          end
        end
      end
    end
  endtask

  task automatic step(input logic [18:0] a, input logic rd, wr, isd, sel,
                      input logic we, input logic [3:0] idx, input logic [22:0] wd,
                      input string tag);
    logic eh, ee;
    logic [9:0] ea;
    @(negedge clk);
    bus_waddr = a; bus_rd = rd; bus_wr = wr; bus_is_data = isd; ram_sel = sel;
    cfg_we = we; cfg_idx = idx; cfg_wdata = wd;
    model(a, rd, wr, isd, sel, eh, ea, ee);
    @(posedge clk);
    if (we) begin
      if (idx < 8) begin m_base[idx[2:0]] = wd[22:4]; m_size[idx[2:0]] = wd[3:0]; end
      else if (idx == 8) m_dis = wd[0];
    end
    #1;
    chk(tag, "ovl_hit", 32'(ovl_hit), 32'(eh));
    chk(tag, "flash_suppress", 32'(flash_suppress), 32'(eh));
    chk(tag, "ram_addr", 32'(ram_addr), 32'(ea));
    chk(tag, "acc_err", 32'(acc_err), 32'(ee));
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [18:0] base, input logic [3:0] sz, input string tag);
    step('0, 0, 0, 0, 0, 1, idx, {base, sz}, tag);
  endtask

  task automatic rd_data(input logic [18:0] a, input string tag);
    step(a, 1, 0, 1, 0, 0, '0, '0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_size[i] = '0; end
    m_dis = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "ovl_hit reset", 32'(ovl_hit), 0);
    chk("R11", "ram_addr reset", 32'(ram_addr), 0);
    chk("R11", "acc_err reset", 32'(acc_err), 0);
    @(negedge clk); rst = 1'b0;
    rd_data(19'h0, "R11");                 // all regions disabled
    step('0, 1, 0, 0, 1, 0, '0, '0, "R11"); // disable bit clear: no error

    cfg(0, 19'h100, 4'd8, "R1");
    rd_data(19'h17F, "R5");                // top word of 512-byte window
    rd_data(19'h180, "R2");                // just past it
    cfg(1, 19'h1003, 4'd3, "R1");          // misaligned 16-byte window
    rd_data(19'h1000, "R4");
    rd_data(19'h1003, "R4");
    rd_data(19'h1004, "R4");
    cfg(2, 19'h2000, 4'd1, "R2");          // 4-byte window
    rd_data(19'h2000, "R2");
    rd_data(19'h2001, "R2");
    cfg(3, 19'h3000, 4'd15, "R2");         // code above 8 -> 512 bytes
    rd_data(19'h307F, "R2");
    rd_data(19'h3080, "R2");
    cfg(4, 19'h140, 4'd8, "R10");          // overlaps region 0
    rd_data(19'h145, "R10");
    step(19'h145, 0, 0, 0, 0, 0, '0, '0, "R6");
    step(19'h145, 1, 0, 0, 0, 0, '0, '0, "R6"); // instruction fetch
    step(19'h145, 0, 1, 1, 0, 0, '0, '0, "R6"); // write
    step(19'h145, 1, 1, 1, 0, 0, '0, '0, "R6");
    step(19'h145, 1, 0, 1, 1, 0, '0, '0, "R6"); // direct RAM access
    step(19'h145, 1, 0, 1, 0, 1, 4'd0, {19'h100, 4'd0}, "R12"); // disable region 0, same edge
    rd_data(19'h145, "R3");                // now region 4 answers
    step(19'h145, 1, 0, 1, 0, 1, 4'd8, 23'd1, "R12"); // set disable during hit
    rd_data(19'h145, "R9");
    step(19'h10, 1, 0, 1, 1, 0, '0, '0, "R8");
    step(19'h10, 0, 1, 0, 1, 0, '0, '0, "R8");
    step(19'h10, 1, 0, 1, 0, 0, '0, '0, "R8");
    cfg(8, '0, 4'd0, "R9");
    rd_data(19'h145, "R9");
    step('0, 0, 0, 0, 0, 1, 4'd9, 23'h7FFFFF, "R1"); // unused index
    step(19'h10, 1, 0, 1, 1, 0, '0, '0, "R1");
    rd_data(19'h2000, "R1");

    for (int n = 0; n < 4000; n++) begin
      logic [18:0] a;
      int r;
      r = int'($urandom % 16);
      if (r == 0) begin
        logic [3:0] ix;
        ix = 4'($urandom % 10);
        if (ix == 8) step('0, 0, 0, 0, 0, 1, ix, 23'($urandom % 5 == 0), "R12");
        else step(19'($urandom % 1024) << 4 | 19'($urandom % 8), 1, 0, 1, 0, 1, ix,
                  {19'($urandom % 64) << 4 | 19'($urandom % 16), 4'($urandom)}, "R12");
      end else begin
        int j;
        j = int'($urandom % 8);
        a = (r < 12) ? m_base[j] + 19'($urandom % 160) - 19'd16 : 19'($urandom % 2048);
        step(a, 1'($urandom % 8 != 0), 1'($urandom % 8 == 0), 1'($urandom % 6 != 0),
             1'($urandom % 10 == 0), 0, '0, '0, "R7");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule